// File: doc/BRIEF.md
# TFT Panel Strobe Generator

This block produces the line and frame control strobes that a 240x320 portrait TFT panel needs. All of them are timed from a single pixel clock. There are five channels:

- a polarity signal that alternates from line to line,
- a one-clock line strobe,
- a sample strobe,
- a frame-start strobe that stays high for two line times at the head of each frame,
- an active-low gate covering the pixel run plus a short tail.

A pixel window output marks the first pixel-count clocks of that gate, so a data path can time its transfers from it.

Each channel is a wrapping counter with its own period and width. The channels do not start together. When the enable input rises, the polarity channel starts first. The line strobe starts once the polarity count has passed a threshold. The remaining three channels start together once the line count has reached a second threshold. Dropping the enable stops every channel on the next clock. Raising it again replays the same staggered start.

The default parameters give a frame of 329 lines: 320 visible and 9 blanking. The line length is derived from a 6 MHz pixel clock and a 60 Hz frame rate with integer division, which gives 303 clocks per line. All periods, widths and thresholds are parameters.

Top module: `tft_strobe_gen`

## Requirements
- R1: While `en` is low and after reset, `polarity`, `line_stb`, `sample_stb`, `frame_stb` and `pix_win` are 0 and `gate_n` is 1.
- R2: The polarity channel starts on the first clock edge that samples `en` high. It is high for LINE_CLKS clocks and then low for LINE_CLKS clocks, repeating.
- R3: The line strobe starts once the polarity count exceeds POL_LEAD. Its first pulse is therefore POL_LEAD+2 clocks after the polarity channel starts.
- R4: The sample, frame and gate channels start together once the line count reaches LINE_LEAD. This is LINE_LEAD+1 clocks after the line strobe starts.
- R5: `line_stb` is high for LSTB_W clocks out of every LINE_CLKS.
- R6: `sample_stb` is high for SSTB_W clocks out of every LINE_CLKS.
- R7: `frame_stb` is high for FSTART_LINES*LINE_CLKS clocks out of every LINE_CLKS*FRAME_LINES, and it rises together with a gate start.
- R8: `gate_n` is low (active) for PIX_CLKS+GATE_TAIL clocks at the start of every line period of its channel, and high otherwise.
- R9: `pix_win` is high for the first PIX_CLKS clocks of each gate-active interval, and only while `gate_n` is low.
- R10: A clock edge that samples `en` low returns every output to its R1 level. A later enable replays the R2 to R4 start sequence from the beginning.
- R11: Each channel counter stays below that channel's period, and a stopped channel holds its count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run request; low stops all channels |
| polarity | output | 1 | Line-alternating polarity signal |
| line_stb | output | 1 | Per-line strobe, active high |
| sample_stb | output | 1 | Per-line sample strobe, active high |
| frame_stb | output | 1 | Frame-start strobe, active high |
| gate_n | output | 1 | Pixel gate, active low |
| pix_win | output | 1 | Pixel data window, active high |

## Verification
The assertions assume that `en` is a level that is synchronous to `clk` and may change on any cycle. They also assume that the parameters keep every width below its period and both start thresholds below the period they are compared against, so every stage is always released. The bench drives `en` only at falling edges. It uses two parameter sets that meet those limits: a compressed line and frame for dense edge checks, and the default full timing for the true line and frame lengths. It toggles the enable in the middle of a run to cover the stop and the restart.

// File: rtl/tft_strobe_pkg.sv
package tft_strobe_pkg;

  localparam int unsigned NCH    = 5;
  localparam int unsigned CH_POL = 0;
  localparam int unsigned CH_LIN = 1;
  localparam int unsigned CH_SMP = 2;
  localparam int unsigned CH_FRM = 3;
  localparam int unsigned CH_GAT = 4;

  // clocks per line from clock rate, frame rate and line count (integer division)
  function automatic int unsigned line_clks(int unsigned clk_hz, int unsigned frame_hz,
                                            int unsigned lines);
    return (clk_hz / frame_hz) / lines;
  endfunction

  // next value of a counter that wraps to zero after period-1
  function automatic logic [31:0] wrap_next(logic [31:0] cur, int unsigned period);
    return (cur >= 32'(period - 1)) ? 32'd0 : cur + 32'd1;
  endfunction

  // active phase: running and count below the width
  function automatic logic in_phase(logic run, logic [31:0] cur, int unsigned width);
    return run && (cur < 32'(width));
  endfunction

endpackage

// File: rtl/strobe_chan.sv
module strobe_chan
  import tft_strobe_pkg::*;
#(
  parameter int unsigned PERIOD  = 303,
  parameter int unsigned WIDTH   = 1,
  parameter bit          ACT_LOW = 1'b0,
  parameter int unsigned CW      = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [CW-1:0] cnt_o,
  output logic          out_o
);
  logic [CW-1:0] cnt_q;
  logic          act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else             cnt_q <= CW'(wrap_next(32'(cnt_q), PERIOD));
  end

  assign act   = in_phase(run, 32'(cnt_q), WIDTH);
  assign cnt_o = cnt_q;

  generate
    if (ACT_LOW) begin : g_low
      assign out_o = ~act;
    end else begin : g_high
      assign out_o = act;
    end
  endgenerate
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq #(
  parameter int unsigned CW        = 17,
  parameter int unsigned POL_LEAD  = 11,
  parameter int unsigned LINE_LEAD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] pol_cnt,
  input  logic [CW-1:0] lin_cnt,
  output logic          rel_pol,
  output logic          rel_lin,
  output logic          rel_rest
);
  logic pol_past, lin_reached;

  assign pol_past    = pol_cnt > CW'(POL_LEAD);
  assign lin_reached = lin_cnt >= CW'(LINE_LEAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_pol  <= 1'b0;
      rel_lin  <= 1'b0;
      rel_rest <= 1'b0;
    end else if (!en) begin
      rel_pol  <= 1'b0;
      rel_lin  <= 1'b0;
      rel_rest <= 1'b0;
    end else begin
      rel_pol <= 1'b1;
      if (rel_pol && pol_past) rel_lin <= 1'b1;
      if (rel_lin && lin_reached) rel_rest <= 1'b1;
    end
  end
endmodule

// File: rtl/tft_strobe_gen.sv
module tft_strobe_gen
  import tft_strobe_pkg::*;
#(
  parameter int unsigned PIX_HZ       = 6_000_000,
  parameter int unsigned FRAME_HZ     = 60,
  parameter int unsigned FRAME_LINES  = 329,
  parameter int unsigned LINE_CLKS    = line_clks(PIX_HZ, FRAME_HZ, FRAME_LINES),
  parameter int unsigned PIX_CLKS     = 240,
  parameter int unsigned GATE_TAIL    = 8,
  parameter int unsigned LSTB_W       = 1,
  parameter int unsigned SSTB_W       = 1,
  parameter int unsigned FSTART_LINES = 2,
  parameter int unsigned POL_LEAD     = 11,
  parameter int unsigned LINE_LEAD    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic polarity,
  output logic line_stb,
  output logic sample_stb,
  output logic frame_stb,
  output logic gate_n,
  output logic pix_win
);
  localparam int unsigned FRAME_CLKS = LINE_CLKS * FRAME_LINES;
  localparam int unsigned CW         = $clog2(FRAME_CLKS + 1);
  localparam int unsigned PER [NCH] = '{2*LINE_CLKS, LINE_CLKS, LINE_CLKS, FRAME_CLKS, LINE_CLKS};
  localparam int unsigned WID [NCH] = '{LINE_CLKS, LSTB_W, SSTB_W, FSTART_LINES*LINE_CLKS,
                                        PIX_CLKS + GATE_TAIL};
  localparam bit          LOW [NCH] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  logic                   rel_pol, rel_lin, rel_rest;
  logic [NCH-1:0]         run;
  logic [NCH-1:0]         outs;
  logic [NCH-1:0][CW-1:0] cnt;

  strobe_seq #(.CW(CW), .POL_LEAD(POL_LEAD), .LINE_LEAD(LINE_LEAD)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .pol_cnt (cnt[CH_POL]),
    .lin_cnt (cnt[CH_LIN]),
    .rel_pol (rel_pol),
    .rel_lin (rel_lin),
    .rel_rest(rel_rest)
  );

  assign run = {rel_rest, rel_rest, rel_rest, rel_lin, rel_pol};

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      strobe_chan #(.PERIOD(PER[i]), .WIDTH(WID[i]), .ACT_LOW(LOW[i]), .CW(CW)) u_ch (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run[i]),
        .cnt_o(cnt[i]),
        .out_o(outs[i])
      );
    end
  endgenerate

  assign polarity   = outs[CH_POL];
  assign line_stb   = outs[CH_LIN];
  assign sample_stb = outs[CH_SMP];
  assign frame_stb  = outs[CH_FRM];
  assign gate_n     = outs[CH_GAT];
  assign pix_win    = in_phase(run[CH_GAT], 32'(cnt[CH_GAT]), PIX_CLKS);
endmodule

// File: rtl/tft_strobe_chk.sv
module tft_strobe_chk
  import tft_strobe_pkg::*;
#(
  parameter int unsigned CW = 17,
  parameter int unsigned PER [NCH] = '{2, 1, 1, 1, 1}
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   en,
  input logic                   polarity,
  input logic                   line_stb,
  input logic                   sample_stb,
  input logic                   frame_stb,
  input logic                   gate_n,
  input logic                   pix_win,
  input logic                   rel_pol,
  input logic                   rel_lin,
  input logic                   rel_rest,
  input logic [NCH-1:0]         run,
  input logic [NCH-1:0][CW-1:0] cnt
);
  // R10: disable idles every output one edge later
  assert_idle_on_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!polarity && !line_stb && !sample_stb && !frame_stb && gate_n && !pix_win));

  // R3: line stage only ever starts behind the polarity stage
  assert_line_after_pol_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_lin) |-> $past(rel_pol));

  // R4: the last three channels start only behind the line stage
  assert_rest_after_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_rest) |-> $past(rel_lin));

  // R2: polarity stage stops only after a disable
  assert_pol_stop_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rel_pol) |-> !$past(en));

  // R9: pixel window lies inside the active gate
  assert_win_in_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_win |-> !gate_n);

  // R7: frame strobe rises together with a gate start
  assert_frame_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_stb) |-> !gate_n);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_c
      // R11: counter below period; stopped channel clears
      assert_cnt_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[i] < CW'(PER[i]));
      assert_cnt_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run[i] |=> cnt[i] == '0);
    end
  endgenerate
endmodule

bind tft_strobe_gen tft_strobe_chk #(.CW(CW), .PER(PER)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .polarity  (polarity),
  .line_stb  (line_stb),
  .sample_stb(sample_stb),
  .frame_stb (frame_stb),
  .gate_n    (gate_n),
  .pix_win   (pix_win),
  .rel_pol   (rel_pol),
  .rel_lin   (rel_lin),
  .rel_rest  (rel_rest),
  .run       (run),
  .cnt       (cnt)
);

// File: tb/tb_tft_strobe_gen.sv
module tb_tft_strobe_gen;
  // compressed timing for the small instance
  localparam int SL = 20, SF = 5, SPX = 10, STL = 2, SLW = 1, SSW = 2, SFL = 2, TP = 11, TL = 3;
  // default full timing
  localparam int FL_L = 303, FL_F = 329;

  localparam int NTAB = 13;
  localparam int TAB_N [NTAB] = '{0, 12, 13, 14, 17, 18, 19, 20, 27, 29, 33, 57, 117};
  // bits {polarity, line_stb, sample_stb, frame_stb, gate_n, pix_win}
  localparam logic [5:0] TAB_V [NTAB] = '{6'b100010, 6'b100010, 6'b110010, 6'b100010,
    6'b101101, 6'b101101, 6'b100101, 6'b000101, 6'b000100, 6'b000110, 6'b010110,
    6'b101001, 6'b001101};

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic s_pol, s_lin, s_smp, s_frm, s_gat, s_pix;
  logic f_pol, f_lin, f_smp, f_frm, f_gat, f_pix;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  tft_strobe_gen #(.LINE_CLKS(SL), .FRAME_LINES(SF), .PIX_CLKS(SPX), .GATE_TAIL(STL),
    .LSTB_W(SLW), .SSTB_W(SSW), .FSTART_LINES(SFL), .POL_LEAD(TP), .LINE_LEAD(TL)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .polarity(s_pol), .line_stb(s_lin),
    .sample_stb(s_smp), .frame_stb(s_frm), .gate_n(s_gat), .pix_win(s_pix));

  tft_strobe_gen dut_full (
    .clk(clk), .rst_n(rst_n), .en(en), .polarity(f_pol), .line_stb(f_lin),
    .sample_stb(f_smp), .frame_stb(f_frm), .gate_n(f_gat), .pix_win(f_pix));

  function automatic logic [5:0] expv(int n, int L, int F, int PX, int TLW, int LW, int SW,
                                      int FLN, int tp, int tl);
    int ls = tp + 2;
    int rs = ls + tl + 1;
    int m  = n - rs;
    logic p, a, b, c, g, w;
    p = (n >= 0) && ((n % (2*L)) < L);
    a = (n >= ls) && (((n - ls) % L) < LW);
    b = (n >= rs) && ((m % L) < SW);
    c = (n >= rs) && ((m % (L*F)) < FLN*L);
    g = !((n >= rs) && ((m % L) < PX + TLW));
    w = (n >= rs) && ((m % L) < PX);
    return {p, a, b, c, g, w};
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp, int n);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d actual=%b expected=%b", req, n, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: idle levels after reset with en low
    check("R1 small", {s_pol, s_lin, s_smp, s_frm, s_gat, s_pix}, 6'b000010, -1);
    check("R1 full",  {f_pol, f_lin, f_smp, f_frm, f_gat, f_pix}, 6'b000010, -1);

    en = 1'b1;
    for (int n = 0; n < 800; n++) begin
      @(negedge clk);
      // R2 R3 R4 R5 R6 R7 R8 R9 R11: per-cycle comparison against the timing model
      check("R2-R9 small", {s_pol, s_lin, s_smp, s_frm, s_gat, s_pix},
            expv(n, SL, SF, SPX, STL, SLW, SSW, SFL, TP, TL), n);
      check("R2-R9 full", {f_pol, f_lin, f_smp, f_frm, f_gat, f_pix},
            expv(n, FL_L, FL_F, 240, 8, 1, 1, 2, 11, 3), n);
      for (int k = 0; k < NTAB; k++)
        if (TAB_N[k] == n)
          check("R3 R4 R7 table", {s_pol, s_lin, s_smp, s_frm, s_gat, s_pix}, TAB_V[k], n);
    end

    // R10: disable idles everything on the next edge
    en = 1'b0;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      check("R10 stop small", {s_pol, s_lin, s_smp, s_frm, s_gat, s_pix}, 6'b000010, n);
      check("R10 stop full",  {f_pol, f_lin, f_smp, f_frm, f_gat, f_pix}, 6'b000010, n);
    end

    // R10: re-enable replays the staggered start
    en = 1'b1;
    for (int n = 0; n < 150; n++) begin
      @(negedge clk);
      check("R10 restart", {s_pol, s_lin, s_smp, s_frm, s_gat, s_pix},
            expv(n, SL, SF, SPX, STL, SLW, SSW, SFL, TP, TL), n);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule